// File: doc/BRIEF.md
# Indirect Post-Indexed Address Generator

This block forms the effective address of a compact memory-reference instruction. The base of the instruction names one of seven scratchpad registers. That register points to a table of array pointers. The caller hands over both instruction halfwords together with the contents of the selected scratchpad register and the selected index register. A mode flag chooses 32-bit or 64-bit addressing. The block scales the 11-bit displacement by the pointer size to pick one table entry. It issues a single memory read to fetch that pointer and adds the unscaled index to the value returned. The result leaves the block with a one-cycle valid strobe, together with the reassembled 7-bit opcode and the destination field.

A second, direct form skips the table. It adds the index straight to the base and ignores the displacement. That form is legal only when its destination field is zero. Otherwise the block raises a one-cycle illegal-format strobe and produces no address. The block takes one instruction at a time and shows through `in_ready` when it can accept the next one.

Top module: `ipx_agen`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `in_ready` is 1 and `mem_req`, `ea_valid` and `ea_illegal` are 0.
- R2: The reported opcode is {`ins_hi[15:14]`, `ins_lo[15:11]`}, so its two most significant bits come from the second halfword. The reported destination is `ins_lo[10:8]`.
- R3: For the indirect form, `mem_addr` equals base + (`ins_hi[10:0]` << 2) when `wide_mode` is 0 and base + (`ins_hi[10:0]` << 3) when it is 1. This includes the largest displacement, 2047.
- R4: A base selector `ins_lo[7:5]` of 0 gives a base of zero. An index selector `ins_lo[4:2]` of 0 gives an index of zero, whatever the register-content inputs carry.
- R5: Once `mem_req` rises, it stays high and `mem_addr` holds its value until `mem_rvalid` is seen. After that, `mem_req` drops.
- R6: The indirect result is the fetched pointer plus the index. In 32-bit mode only `mem_rdata[31:0]` is used, zero-extended. In 64-bit mode all 64 bits are used.
- R7: When `direct_form` is 1 and the destination field is 0, the result is base + index. The displacement is ignored and no memory request is made.
- R8: When `direct_form` is 1 and the destination field is non-zero, `ea_illegal` pulses for one cycle instead of `ea_valid`, and no memory request is made.
- R9: `ea_valid` and `ea_illegal` are single-cycle pulses and never high together. `in_ready` is low from acceptance until the result pulse. `in_valid` asserted while `in_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle; instruction taken when both are high |
| ins_lo | input | 16 | First instruction halfword |
| ins_hi | input | 16 | Second instruction halfword |
| wide_mode | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| direct_form | input | 1 | 1 = base + index with no pointer fetch |
| spad_val | input | 64 | Contents of the selected scratchpad register |
| idx_val | input | 64 | Contents of the selected index register |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 64 | Pointer table entry address |
| mem_rvalid | input | 1 | Pointer data returned |
| mem_rdata | input | 64 | Returned pointer data |
| ea_valid | output | 1 | Final address strobe |
| ea_addr | output | 64 | Final effective address |
| ea_opcode | output | 7 | Reassembled opcode |
| ea_dest | output | 3 | Destination register field |
| ea_illegal | output | 1 | Direct form with non-zero destination |

## Verification
Two situations are hard to reach from the ports. The first is a pointer fetch that stalls for several cycles while the caller keeps offering new instructions with `in_valid` high. The second is a 32-bit fetch whose returned word carries non-zero upper bits. The responder in the bench stretches its latency for chosen instructions and always returns data with a non-zero upper half. During those stalls the driver offers junk instructions. Any extra result, or any change to the held address, then shows up at the monitor.

// File: rtl/ipx_pkg.sv
// Package: shared state encoding and instruction field positions for the
// indirect post-indexed address generator. Assumes the field layout given
// in the brief (opcode split across both halfwords).
package ipx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } ipx_state_e;

    localparam int OPC_W      = 7;
    localparam int OPC_LO_W   = 5;
    localparam int REGSEL_W   = 3;
    localparam int DISP_W     = 11;
    localparam int LO_OPC_MSB = 15;
    localparam int LO_DST_MSB = 10;
    localparam int LO_BAS_MSB = 7;
    localparam int LO_IDX_MSB = 4;
    localparam int HI_OPC_MSB = 15;
endpackage

// File: rtl/ipx_decode.sv
// ipx_decode: pulls the fields out of the two halfwords, reassembles the
// split opcode, masks register contents whose selector is zero and forms
// the pointer-table address. Purely combinational; assumes the caller has
// already read the named registers.
module ipx_decode
    import ipx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [15:0]          ins_lo,
    input  logic [15:0]          ins_hi,
    input  logic                 wide_mode,
    input  logic [XLEN-1:0]      spad_val,
    input  logic [XLEN-1:0]      idx_val,
    output logic [OPC_W-1:0]     opcode,
    output logic [REGSEL_W-1:0]  dest,
    output logic [XLEN-1:0]      base_eff,
    output logic [XLEN-1:0]      idx_eff,
    output logic [XLEN-1:0]      tbl_addr
);
    localparam int SHIFT_NARROW = 2;
    localparam int SHIFT_WIDE   = 3;

    logic [REGSEL_W-1:0] base_sel;
    logic [REGSEL_W-1:0] idx_sel;
    logic [DISP_W-1:0]   disp;
    logic [XLEN-1:0]     disp_ext;
    logic [XLEN-1:0]     disp_scaled;

    // Field extraction and opcode reassembly (high bits from second halfword).
    always_comb begin
        opcode   = {ins_hi[HI_OPC_MSB -: OPC_W-OPC_LO_W], ins_lo[LO_OPC_MSB -: OPC_LO_W]};
        dest     = ins_lo[LO_DST_MSB -: REGSEL_W];
        base_sel = ins_lo[LO_BAS_MSB -: REGSEL_W];
        idx_sel  = ins_lo[LO_IDX_MSB -: REGSEL_W];
        disp     = ins_hi[DISP_W-1:0];
    end

    // Selector zero stands for a zero operand.
    always_comb begin
        base_eff = (base_sel == '0) ? '0 : spad_val;
        idx_eff  = (idx_sel  == '0) ? '0 : idx_val;
    end

    // Scale displacement by pointer size and add the table base.
    always_comb begin
        disp_ext    = {{(XLEN-DISP_W){1'b0}}, disp};
        disp_scaled = wide_mode ? (disp_ext << SHIFT_WIDE) : (disp_ext << SHIFT_NARROW);
        tbl_addr    = base_eff + disp_scaled;
    end
endmodule

// File: rtl/ipx_ptr_fmt.sv
// ipx_ptr_fmt: turns returned read data into a pointer. In narrow mode
// only the low PTR_NARROW bits are kept and zero-extended. Assumes
// XLEN >= PTR_NARROW.
module ipx_ptr_fmt #(
    parameter int XLEN       = 64,
    parameter int PTR_NARROW = 32
) (
    input  logic            wide,
    input  logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] ptr
);
    generate
        if (XLEN > PTR_NARROW) begin : g_ext
            // Zero-extend narrow pointer unless the wide mode is active.
            always_comb ptr = wide ? rdata : {{(XLEN-PTR_NARROW){1'b0}}, rdata[PTR_NARROW-1:0]};
        end else begin : g_pass
            // Path already narrow: pass straight through.
            always_comb ptr = rdata;
        end
    endgenerate
endmodule

// File: rtl/ipx_seq.sv
// ipx_seq: control for one instruction at a time. It accepts when idle,
// either finishes a direct form at once or holds a pointer read until the
// data returns, then strobes the result for one cycle. Synchronous
// active-low reset.
module ipx_seq
    import ipx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 wide_mode,
    input  logic                 direct_form,
    input  logic [OPC_W-1:0]     opcode,
    input  logic [REGSEL_W-1:0]  dest,
    input  logic [XLEN-1:0]      base_eff,
    input  logic [XLEN-1:0]      idx_eff,
    input  logic [XLEN-1:0]      tbl_addr,
    output logic                 mem_req,
    output logic [XLEN-1:0]      mem_addr,
    input  logic                 mem_rvalid,
    input  logic [XLEN-1:0]      mem_rdata,
    output logic                 ea_valid,
    output logic [XLEN-1:0]      ea_addr,
    output logic [OPC_W-1:0]     ea_opcode,
    output logic [REGSEL_W-1:0]  ea_dest,
    output logic                 ea_illegal
);
    ipx_state_e          state_q;
    logic [OPC_W-1:0]    op_q;
    logic [REGSEL_W-1:0] dest_q;
    logic [XLEN-1:0]     idx_q;
    logic [XLEN-1:0]     addr_q;
    logic [XLEN-1:0]     ea_q;
    logic                wide_q;
    logic                bad_q;
    logic [XLEN-1:0]     ptr;

    ipx_ptr_fmt #(.XLEN(XLEN), .PTR_NARROW(32)) u_ptr (
        .wide  (wide_q),
        .rdata (mem_rdata),
        .ptr   (ptr)
    );

    // State machine and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            dest_q  <= '0;
            idx_q   <= '0;
            addr_q  <= '0;
            ea_q    <= '0;
            wide_q  <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (in_valid) begin
                    op_q   <= opcode;
                    dest_q <= dest;
                    idx_q  <= idx_eff;
                    wide_q <= wide_mode;
                    if (direct_form) begin
                        ea_q    <= base_eff + idx_eff;
                        bad_q   <= (dest != '0);
                        state_q <= ST_DONE;
                    end else begin
                        addr_q  <= tbl_addr;
                        bad_q   <= 1'b0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_rvalid) begin
                    ea_q    <= ptr + idx_q;
                    state_q <= ST_DONE;
                end
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from state.
    always_comb begin
        in_ready   = (state_q == ST_IDLE);
        mem_req    = (state_q == ST_FETCH);
        mem_addr   = addr_q;
        ea_valid   = (state_q == ST_DONE) && !bad_q;
        ea_illegal = (state_q == ST_DONE) && bad_q;
        ea_addr    = ea_q;
        ea_opcode  = op_q;
        ea_dest    = dest_q;
    end

    // R1: idle and quiet right after reset.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !mem_req && !ea_valid && !ea_illegal));

    // R5: request and address held until data returns.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R5: request drops once data is taken.
    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> !mem_req);

    // R9: result strobes are single-cycle and exclusive.
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid || ea_illegal) |=> !(ea_valid || ea_illegal));
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ea_valid && ea_illegal));

    // R8/R9: an accepted direct form never issues a read.
    p_direct_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid && direct_form) |=> !mem_req);
endmodule

// File: rtl/ipx_agen.sv
// ipx_agen: top of the indirect post-indexed address generator. It ties
// field decode to the control sequencer. Assumes 64-bit register contents
// and a one-instruction-at-a-time caller.
module ipx_agen
    import ipx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [15:0]     ins_lo,
    input  logic [15:0]     ins_hi,
    input  logic            wide_mode,
    input  logic            direct_form,
    input  logic [XLEN-1:0] spad_val,
    input  logic [XLEN-1:0] idx_val,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            ea_valid,
    output logic [XLEN-1:0] ea_addr,
    output logic [6:0]      ea_opcode,
    output logic [2:0]      ea_dest,
    output logic            ea_illegal
);
    logic [OPC_W-1:0]    opcode;
    logic [REGSEL_W-1:0] dest;
    logic [XLEN-1:0]     base_eff;
    logic [XLEN-1:0]     idx_eff;
    logic [XLEN-1:0]     tbl_addr;

    ipx_decode #(.XLEN(XLEN)) u_dec (
        .ins_lo    (ins_lo),
        .ins_hi    (ins_hi),
        .wide_mode (wide_mode),
        .spad_val  (spad_val),
        .idx_val   (idx_val),
        .opcode    (opcode),
        .dest      (dest),
        .base_eff  (base_eff),
        .idx_eff   (idx_eff),
        .tbl_addr  (tbl_addr)
    );

    ipx_seq #(.XLEN(XLEN)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .wide_mode   (wide_mode),
        .direct_form (direct_form),
        .opcode      (opcode),
        .dest        (dest),
        .base_eff    (base_eff),
        .idx_eff     (idx_eff),
        .tbl_addr    (tbl_addr),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .ea_valid    (ea_valid),
        .ea_addr     (ea_addr),
        .ea_opcode   (ea_opcode),
        .ea_dest     (ea_dest),
        .ea_illegal  (ea_illegal)
    );
endmodule

// File: tb/ipx_agen_bench.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them, and a memory responder serves pointer reads.
module ipx_agen_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        illegal;
        logic [63:0] addr;
        logic [6:0]  opc;
        logic [2:0]  dest;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic        in_ready;
    logic [15:0] ins_lo = 0, ins_hi = 0;
    logic        wide_mode = 0, direct_form = 0;
    logic [63:0] spad_val = 0, idx_val = 0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 0;
    logic [63:0] mem_rdata = 0;
    logic        ea_valid;
    logic [63:0] ea_addr;
    logic [6:0]  ea_opcode;
    logic [2:0]  ea_dest;
    logic        ea_illegal;

    int   n_checks = 0, n_fail = 0;
    exp_t exp_q[$];
    logic [63:0] mreq_q[$];
    int   lat = 1;
    int   req_cnt = 0;
    logic [63:0] held_addr = 0;
    bit   done = 0;

    ipx_agen u_ipx_agen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .ins_lo(ins_lo), .ins_hi(ins_hi), .wide_mode(wide_mode),
        .direct_form(direct_form), .spad_val(spad_val), .idx_val(idx_val),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .ea_valid(ea_valid), .ea_addr(ea_addr),
        .ea_opcode(ea_opcode), .ea_dest(ea_dest), .ea_illegal(ea_illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] mem_fn(input logic [63:0] a);
        return {a[31:0] ^ 32'hDEAD_BEEF, a[31:0] + 32'h0100_0000};
    endfunction

    task automatic check(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Driver: offer one instruction, push expected result (and read address).
    task automatic issue(input string tag, input logic [6:0] opc, input logic [2:0] dst,
                         input logic [2:0] bsel, input logic [2:0] isel, input logic [10:0] disp,
                         input logic wide, input logic direct, input logic [63:0] sv,
                         input logic [63:0] iv, input int latency, input bit junk);
        logic [63:0] base, idx, tbl, ptr, rd;
        exp_t e;
        base = (bsel == 0) ? 64'd0 : sv;
        idx  = (isel == 0) ? 64'd0 : iv;
        tbl  = base + ({53'd0, disp} << (wide ? 3 : 2));
        e.opc = opc; e.dest = dst;
        if (direct) begin
            e.illegal = (dst != 0);
            e.addr    = e.illegal ? 64'd0 : base + idx;
        end else begin
            rd  = mem_fn(tbl);
            ptr = wide ? rd : {32'd0, rd[31:0]};
            e.illegal = 1'b0;
            e.addr    = ptr + idx;
            mreq_q.push_back(tbl);
        end
        while (!in_ready) @(negedge clk);
        lat = latency;
        exp_q.push_back(e);
        ins_lo = {opc[4:0], dst, bsel, isel, 2'b00};
        ins_hi = {opc[6:5], 3'b000, disp};
        wide_mode = wide; direct_form = direct; spad_val = sv; idx_val = iv;
        in_valid = 1;
        @(negedge clk);
        if (junk) begin
            // R9: offers while busy must be ignored.
            ins_lo = 16'hFFFC; ins_hi = 16'hC7FF; direct_form = 1; idx_val = 64'h55;
            @(negedge clk);
            @(negedge clk);
        end
        in_valid = 0;
        $display("issued %s", tag);
    endtask

    // Memory responder: check address and hold, return data after latency.
    always @(negedge clk) begin
        if (mem_rvalid) mem_rvalid <= 0;
        if (rst_n && mem_req && !mem_rvalid) begin
            if (req_cnt == 0) begin
                if (mreq_q.size() == 0)
                    check("R7 unexpected read", 1'b0, mem_addr, 64'd0);
                else
                    check("R3 table address", mem_addr == mreq_q[0], mem_addr, mreq_q[0]);
                if (mreq_q.size() != 0) void'(mreq_q.pop_front());
                held_addr = mem_addr;
            end else begin
                check("R5 address held", mem_addr == held_addr, mem_addr, held_addr);
            end
            req_cnt++;
            if (req_cnt >= lat) begin
                mem_rvalid <= 1;
                mem_rdata  <= mem_fn(mem_addr);
                req_cnt = 0;
            end
        end
    end

    // Monitor: compare every result strobe against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && (ea_valid || ea_illegal)) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected result", 1'b0, ea_addr, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.illegal ? "R8 illegal strobe" : "R9 valid strobe",
                      ea_illegal == e.illegal && ea_valid == !e.illegal,
                      {62'd0, ea_valid, ea_illegal}, {62'd0, !e.illegal, e.illegal});
                if (!e.illegal) begin
                    check("R6/R7 address", ea_addr == e.addr, ea_addr, e.addr);
                    check("R2 opcode", ea_opcode == e.opc, {57'd0, ea_opcode}, {57'd0, e.opc});
                    check("R2 dest", ea_dest == e.dest, {61'd0, ea_dest}, {61'd0, e.dest});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset in_ready", in_ready == 1, {63'd0, in_ready}, 64'd1);
        check("R1 reset quiet", !mem_req && !ea_valid && !ea_illegal,
              {61'd0, mem_req, ea_valid, ea_illegal}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        // R3 R6: narrow indirect, one-cycle read.
        issue("R3 narrow", 7'h5A, 3'd2, 3'd3, 3'd2, 11'd5, 0, 0, 64'h1000, 64'h10, 1, 0);
        // R3 R9: wide, largest displacement, stalled read with junk offers; index sel 0.
        issue("R4 wide max", 7'h13, 3'd7, 3'd1, 3'd0, 11'h7FF, 1, 0, 64'h0000_8000_0000_0000, 64'hFFFF, 4, 1);
        // R4: base selector 0 ignores scratchpad value.
        issue("R4 base zero", 7'h60, 3'd1, 3'd0, 3'd5, 11'd9, 0, 0, 64'hABCD_0000, 64'h3, 2, 0);
        // R6: narrow mode near 32-bit top, upper read bits discarded.
        issue("R6 narrow ext", 7'h01, 3'd4, 3'd6, 3'd1, 11'd100, 0, 0, 64'hFFFF_F000, 64'h8, 3, 1);
        // R7: direct form, displacement ignored.
        issue("R7 direct", 7'h7F, 3'd0, 3'd2, 3'd3, 11'h7FF, 1, 1, 64'h2000, 64'h24, 1, 0);
        // R8: direct form with non-zero destination.
        issue("R8 illegal", 7'h22, 3'd5, 3'd2, 3'd3, 11'd0, 0, 1, 64'h2000, 64'h24, 1, 0);
        // R6: wide back-to-back with long latency.
        issue("R6 wide long", 7'h40, 3'd3, 3'd7, 3'd4, 11'd1, 1, 0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h100, 6, 0);
        issue("R6 wide next", 7'h3F, 3'd6, 3'd5, 3'd2, 11'd2, 1, 0, 64'h40, 64'h7, 1, 0);
        repeat (12) @(negedge clk);
        check("R9 scoreboard drained", exp_q.size() == 0, 64'(exp_q.size()), 64'd0);
        check("R9 idle at end", in_ready == 1, {63'd0, in_ready}, 64'd1);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule